// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands of `OP_W` bits over several clock cycles and returns a product of twice that width. A one-cycle start request taken while the block is idle captures both operands. The multiplicand goes into a register of double width, in its low half. The multiplier goes into a register of single width. The product register is cleared.

The block then runs exactly `OP_W` iterations, one per clock. In each iteration the lowest bit of the multiplier register decides whether the double-width multiplicand is added into the product. After that decision the multiplicand moves one place left and the multiplier moves one place right.

A controller sequences the work and drives the datapath through a small bundle of strobes. It raises `busy` for the whole operation and pulses `done` for one cycle when the last iteration has been applied. The product then stays on the output until the next accepted start.

Top module: `shiftadd_mul`

## Requirements
- R1: When `done` is high, `product` equals the unsigned product of the `opA` and `opB` values captured by the accepted start, as a full `2*OP_W`-bit value with no truncation.
- R2: A start request (`start` high on a rising edge while `busy` is low) is accepted: from the next cycle `busy` is high and `product` reads zero.
- R3: Exactly `OP_W` iterations run. If a start is accepted at edge E0, `done` is high in the cycle that follows edge E0+`OP_W`, and in no earlier cycle of that operation.
- R4: `done` is high for exactly one cycle, and `busy` is low in that same cycle.
- R5: A start request while `busy` is high is ignored: neither the operands in use nor the completion time change.
- R6: While `busy` is low and no start is given, `product` holds its value.
- R7: A synchronous active-high `rst` forces `busy` low, `done` low and `product` to zero on the next edge, and an operation in progress is abandoned.
- R8: After k iterations (0 <= k <= `OP_W`), `product` equals `opA` times the low k bits of `opB`. An iteration whose multiplier bit is 0 leaves `product` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start request, sampled on each rising edge |
| opA | input | OP_W | Multiplicand operand |
| opB | input | OP_W | Multiplier operand |
| busy | output | 1 | High while an operation is running |
| done | output | 1 | One-cycle pulse marking the final product |
| product | output | 2*OP_W | Running, then final, product |

## Verification
The bench builds the multiplier with `OP_W = 8`. With that width one operation takes a handful of cycles, so the extreme operands (zero, one, all ones on both sides), the full 16-bit result of the largest square and a back-to-back start in the `done` cycle can all be covered directly. The same width makes it cheap to sample the running product halfway through and compare it against the partial product of the low multiplier bits. It also leaves room to inject a start during a run and a reset during a run, and then confirm that the completion cycle and the result do not change.

// File: rtl/shiftadd_pkg.sv
package shiftadd_pkg;

  // Strobes sent from the sequencer to the arithmetic datapath.
  typedef struct packed {
    logic load;   // capture operands, clear product
    logic step;   // perform one add/shift iteration
  } mulStrobes_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mulState_t;

endpackage

// File: rtl/shiftadd_ctrl.sv
module shiftadd_ctrl
  import shiftadd_pkg::*;
#(
  parameter int OP_W = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output mulStrobes_t strobes,
  output logic        busy,
  output logic        done
);

  localparam int CNT_W = $clog2(OP_W) + 1;
  localparam logic [CNT_W-1:0] LAST_ITER = CNT_W'(OP_W - 1);

  mulState_t        state;
  mulState_t        stateNext;
  logic [CNT_W-1:0] iterCnt;
  logic             accept;
  logic             lastStep;

  assign accept   = start && (state == ST_IDLE);
  assign lastStep = (state == ST_RUN) && (iterCnt == LAST_ITER);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (accept)   stateNext = ST_RUN;
      ST_RUN:  if (lastStep) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobes      = '0;
    strobes.load = accept;
    strobes.step = (state == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= lastStep;
      if (accept) begin
        iterCnt <= '0;
      end else if (state == ST_RUN) begin
        iterCnt <= iterCnt + 1'b1;
      end
    end
  end

  assign busy = (state == ST_RUN);

  // Counter never passes the final iteration index while running.
  AST_ITER_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (iterCnt <= LAST_ITER)); // R3

  // Completion pulse lasts one cycle.
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R4

  // Completion only follows the final iteration of a run.
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
    lastStep |=> (done && !busy)); // R3

  // A start while running leaves the count advancing.
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !lastStep) |=> (busy && iterCnt == $past(iterCnt) + 1'b1)); // R5

  // Reset leaves the sequencer idle with no completion.
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!busy && !done)); // R7

endmodule

// File: rtl/shiftadd_datapath.sv
module shiftadd_datapath
  import shiftadd_pkg::*;
#(
  parameter int OP_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  mulStrobes_t       strobes,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic [2*OP_W-1:0] product
);

  localparam int PROD_W = 2 * OP_W;

  logic [PROD_W-1:0] mcandReg;
  logic [OP_W-1:0]   mplierReg;
  logic [PROD_W-1:0] prodReg;
  logic [PROD_W-1:0] sum;

  // Full-width adder feeding the product register.
  assign sum = prodReg + mcandReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      mcandReg  <= '0;
      mplierReg <= '0;
      prodReg   <= '0;
    end else if (strobes.load) begin
      mcandReg  <= {{OP_W{1'b0}}, opA};
      mplierReg <= opB;
      prodReg   <= '0;
    end else if (strobes.step) begin
      if (mplierReg[0]) begin
        prodReg <= sum;
      end
      mcandReg  <= {mcandReg[PROD_W-2:0], 1'b0};
      mplierReg <= {1'b0, mplierReg[OP_W-1:1]};
    end
  end

  assign product = prodReg;

  // Loading clears the accumulated product.
  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> (prodReg == '0)); // R2

  // A zero multiplier bit skips the addition.
  AST_SKIP_ADD: assert property (@(posedge clk) disable iff (rst)
    (strobes.step && !strobes.load && !mplierReg[0]) |=> $stable(prodReg)); // R8

  // With no strobe the datapath holds.
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!strobes.step && !strobes.load) |=> $stable(prodReg)); // R6

  // Multiplicand advances one place per iteration.
  AST_MCAND_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (strobes.step && !strobes.load) |=> (mcandReg == ($past(mcandReg) << 1))); // R8

  // Reset clears the product.
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (prodReg == '0)); // R7

endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul
  import shiftadd_pkg::*;
#(
  parameter int OP_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic              busy,
  output logic              done,
  output logic [2*OP_W-1:0] product
);

  mulStrobes_t strobes;

  shiftadd_ctrl #(.OP_W(OP_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .strobes (strobes),
    .busy    (busy),
    .done    (done)
  );

  shiftadd_datapath #(.OP_W(OP_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .product (product)
  );

  // An accepted start raises busy on the next cycle.
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R2

  // Completion coincides with busy dropping.
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R4

  // Product is frozen while idle without a start.
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(product)); // R6

endmodule

// File: tb/tb_shiftadd_mul.sv
module tb_shiftadd_mul;

  localparam int W  = 8;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  opA = '0;
  logic [W-1:0]  opB = '0;
  logic          busy;
  logic          done;
  logic [PW-1:0] product;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [PW-1:0] expQ[$];

  always #2.5 clk = ~clk;

  shiftadd_mul #(.OP_W(W)) dut (
    .clk(clk), .rst(rst), .start(start), .opA(opA), .opB(opB),
    .busy(busy), .done(done), .product(product)
  );

  task automatic check(input bit ok, input string req, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [PW-1:0] mulRef(input logic [W-1:0] a, input logic [W-1:0] b);
    return {{W{1'b0}}, a} * {{W{1'b0}}, b};
  endfunction

  // Monitor: pops expected products as completions appear.
  always @(negedge clk) begin
    if (!rst && done) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R1 unexpected done", product, '0);
      end else begin
        logic [PW-1:0] e;
        e = expQ.pop_front();
        check(product === e, "R1 product", product, e);
        check(busy === 1'b0, "R4 busy low with done", {{(PW-1){1'b0}}, busy}, '0);
      end
    end
  end

  // Driver: issues one operation and checks timing.
  // probeK > 0 samples the running product after probeK iterations.
  // glitchAt > 0 injects a start with other operands during the run.
  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] b,
                       input int probeK, input int glitchAt);
    int cyc;
    while (busy !== 1'b0) @(negedge clk);
    opA = a; opB = b; start = 1'b1;
    expQ.push_back(mulRef(a, b));
    @(negedge clk);
    start = 1'b0;
    opA = ~a; opB = ~b;
    check(busy === 1'b1, "R2 busy after start", {{(PW-1){1'b0}}, busy}, 1);
    check(product === '0, "R2 product cleared", product, '0);
    cyc = 0;
    while (done !== 1'b1 && cyc < 4 * W) begin
      if (glitchAt > 0 && cyc == glitchAt - 1) begin
        start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      cyc++;
      if (probeK > 0 && cyc == probeK) begin
        logic [PW-1:0] e;
        e = mulRef(a, b & W'((1 << probeK) - 1));
        check(product === e, "R8 partial product", product, e);
      end
      if (cyc < W) begin
        check(done === 1'b0, "R3 no early done", {{(PW-1){1'b0}}, done}, '0);
      end
    end
    check(cyc == W, "R3 iteration count", PW'(cyc), PW'(W));
    if (glitchAt > 0) begin
      check(product === mulRef(a, b), "R5 start while busy ignored", product, mulRef(a, b));
    end
  endtask

  task automatic idleHold(input int n);
    logic [PW-1:0] held;
    held = product;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(product === held, "R6 product held while idle", product, held);
      check(done === 1'b0, "R4 single done pulse", {{(PW-1){1'b0}}, done}, '0);
    end
  endtask

  task automatic finishTest();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finishTest();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R7 reset busy", {{(PW-1){1'b0}}, busy}, '0);
    check(done === 1'b0, "R7 reset done", {{(PW-1){1'b0}}, done}, '0);
    check(product === '0, "R7 reset product", product, '0);
    rst = 1'b0;
    @(negedge clk);

    runOp(8'd13, 8'd11, 0, 0);
    idleHold(3);
    runOp(8'hFF, 8'hFF, 0, 0);
    runOp(8'd0, 8'hA5, 0, 0);
    runOp(8'h5A, 8'd0, 0, 0);
    runOp(8'd1, 8'd1, 0, 0);
    runOp(8'hFF, 8'd1, 0, 0);
    runOp(8'h80, 8'h80, 0, 0);
    runOp(8'hC3, 8'hB7, W / 2, 0);
    runOp(8'h9D, 8'h6E, 0, 3);
    idleHold(2);
    // Back-to-back: the next start lands in the done cycle.
    for (int i = 0; i < 6; i++) begin
      runOp(W'(i * 37 + 5), W'(255 - i * 29), 1 + i, 0);
    end

    // Reset during a run abandons it.
    opA = 8'h77; opB = 8'h66; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(busy === 1'b0, "R7 reset mid-run busy", {{(PW-1){1'b0}}, busy}, '0);
    check(product === '0, "R7 reset mid-run product", product, '0);
    idleHold(W + 2);
    runOp(8'h12, 8'h34, 0, 0);
    idleHold(2);
    check(expQ.size() == 0, "R1 all results seen", PW'(expQ.size()), '0);
    finishTest();
  end

endmodule